// File: doc/BRIEF.md
# Header-Driven Block Decompressor

This block rebuilds a 128-byte memory block from its compressed image while the home memory controller serves a cache miss. It receives three values from a directory lookup: a 32-bit locator for the compressed image, a 2-bit block state, and a 32-bit encoding header. From the block state and the 2-bit header code for each double-word, it works out how many 32-bit payload words to fetch and how to place them.

It reads those words one at a time through a request/response port. The port allows any response latency. The block then sends the sixteen rebuilt 64-bit double-words, in order, over a valid/ready output stream.

The block state selects one of four forms: scheme A, scheme B, uncompressed and all-zero. The two schemes differ only in how they read header code 10. Each compressed image starts on an 8-byte boundary, and its payload words follow one another at rising addresses.

Top module: `hdr_block_unpacker`

## Requirements
- R1: After reset `start_ready` is 1 and `out_valid` and `mem_req_valid` are 0. A block is accepted when `start_valid` and `start_ready` are both high. `start_ready` stays low from acceptance until the sixteenth double-word has been taken.
- R2: The first payload read of a block goes to byte address `start_locator` shifted left by 3. Each later read of the same block goes to the previous address plus 4.
- R3: Double-word i (i = 0..15, in output order) is governed by header bits [31-2i : 30-2i], so the top pair describes the first double-word.
- R4: Under block state 00 or 01, header code 00 yields an all-zero double-word and issues no read.
- R5: Under block state 00 or 01, header code 11 issues two reads. The first word returned forms bits [63:32] and the second forms bits [31:0].
- R6: Block state 00 (scheme A) with code 01 yields {32'h0, w}. Scheme A with code 10 yields {w, w}. Here w is the single word read.
- R7: Block state 01 (scheme B) with code 01 yields {32'h0, w}. Scheme B with code 10 yields {w, 32'h0}.
- R8: Block state 10 (uncompressed) ignores the header and issues 32 reads. Double-word i is {word 2i, word 2i+1}.
- R9: Block state 11 (all-zero) issues no reads and yields sixteen zero double-words.
- R10: Exactly sixteen double-words leave per block, in order. `out_last` is high only with the sixteenth. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R11: At most one read is outstanding. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`. The response may arrive any number of cycles (at least one) after acceptance, and the block issues exactly as many reads as R4 to R9 call for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | A block descriptor is offered |
| start_ready | output | 1 | Block is idle and takes a descriptor |
| start_locator | input | 32 | Compressed image locator in 8-byte units |
| start_state | input | 2 | 00 scheme A, 01 scheme B, 10 uncompressed, 11 all-zero |
| start_header | input | 32 | Sixteen 2-bit codes, first double-word in the top pair |
| mem_req_valid | output | 1 | Payload read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 35 | Byte address of the 32-bit payload word |
| mem_rsp_valid | input | 1 | Read data is present for one cycle |
| mem_rsp_data | input | 32 | Returned payload word |
| out_valid | output | 1 | Rebuilt double-word is present |
| out_ready | input | 1 | Consumer takes the double-word |
| out_data | output | 64 | Rebuilt double-word |
| out_last | output | 1 | Marks the sixteenth double-word |

## Verification
The bench applies every header code to every position under all four block states, then mixed and pseudo-random headers under varied response latency and backpressure on both ports.

Several faults are aimed at directly. Swapping the meaning of code 10 between the schemes would duplicate a word where a zero half belongs. Taking header pairs from the low end first would reorder the zero and payload double-words. A wrong shift of the locator or a wrong pointer step would put every read at an unexpected address.

The bench also counts reads. An extra read for code 00 or for an all-zero block shows up in that count, as does a single read for an uncompressed double-word. A design that drops data under backpressure would lose or repeat double-words in the output sequence.

// File: rtl/unpack_pkg.sv
// Package: shared types for the header-driven block decompressor.
// Assumes block-state codes are fixed by the directory entry format.
package unpack_pkg;

    // Block-state values carried in the directory entry
    localparam logic [1:0] BLK_SCHEME_A = 2'b00;
    localparam logic [1:0] BLK_SCHEME_B = 2'b01;
    localparam logic [1:0] BLK_RAW      = 2'b10;
    localparam logic [1:0] BLK_ZERO     = 2'b11;

    // How one double-word is assembled from payload words
    typedef enum logic [2:0] {
        DW_ZERO,   // no payload, all zero
        DW_LOW,    // one word into the low half
        DW_DUP,    // one word into both halves
        DW_HIGH,   // one word into the high half
        DW_FULL    // two words, first is the high half
    } dw_kind_e;

    // Sequencer states
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DECODE,
        SQ_REQ,
        SQ_WAIT,
        SQ_EMIT
    } seq_state_e;

endpackage

// File: rtl/hdr_code_map.sv
// Module: hdr_code_map
// Turns a block state and one 2-bit header code into an assembly kind.
// Purely combinational; assumes the code is already aligned to the
// double-word being decoded.
module hdr_code_map
    import unpack_pkg::*;
(
    input  logic [1:0] blk_state,
    input  logic [1:0] code,
    output dw_kind_e   kind
);

    // Per-code meaning under the selected table
    always_comb begin
        kind = DW_ZERO;
        case (blk_state)
            BLK_ZERO: kind = DW_ZERO;
            BLK_RAW:  kind = DW_FULL;
            default: begin
                case (code)
                    2'b00: kind = DW_ZERO;
                    2'b01: kind = DW_LOW;
                    2'b10: kind = (blk_state == BLK_SCHEME_A) ? DW_DUP : DW_HIGH;
                    default: kind = DW_FULL;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/rd_ptr_gen.sv
// Module: rd_ptr_gen
// Payload byte pointer: loaded from the locator scaled to its alignment,
// stepped by one word each time a read is accepted.
// Assumes load and advance are never high together.
module rd_ptr_gen #(
    parameter int LOC_W    = 32,
    parameter int ALIGN_SH = 3,
    parameter int STEP     = 4,
    localparam int ADDR_W  = LOC_W + ALIGN_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LOC_W-1:0]  base_loc,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Pointer register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= {base_loc, {ALIGN_SH{1'b0}}};
        end else if (advance) begin
            addr <= addr + STEP_V;
        end
    end

    p_no_double_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && advance));

endmodule

// File: rtl/dw_builder.sv
// Module: dw_builder
// Captures up to two payload words and forms the 64-bit double-word
// according to the assembly kind. Assumes the kind is stable while
// the double-word is being emitted.
module dw_builder
    import unpack_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int DW_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cap_second,
    input  logic [WORD_W-1:0] cap_word,
    input  dw_kind_e          kind,
    output logic [DW_W-1:0]   dword
);

    logic [WORD_W-1:0] first_q;
    logic [WORD_W-1:0] second_q;

    // Capture of returned payload words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
        end else if (cap_en) begin
            if (cap_second) second_q <= cap_word;
            else            first_q  <= cap_word;
        end
    end

    // Placement of captured words into the double-word
    always_comb begin
        case (kind)
            DW_LOW:  dword = {{WORD_W{1'b0}}, first_q};
            DW_DUP:  dword = {first_q, first_q};
            DW_HIGH: dword = {first_q, {WORD_W{1'b0}}};
            DW_FULL: dword = {first_q, second_q};
            default: dword = '0;
        endcase
    end

endmodule

// File: rtl/hdr_block_unpacker.sv
// Module: hdr_block_unpacker (top)
// Rebuilds a block of DW_PER_BLK double-words from its compressed image.
// Sequence per double-word: decode the header code, fetch 0..2 payload
// words one at a time, then offer the result on the output stream.
// Assumes a read response arrives at least one cycle after acceptance and
// only while a read is outstanding.
module hdr_block_unpacker
    import unpack_pkg::*;
#(
    parameter int LOC_W      = 32,
    parameter int ALIGN_SH   = 3,
    parameter int WORD_W     = 32,
    parameter int DW_PER_BLK = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_valid,
    output logic                       start_ready,
    input  logic [LOC_W-1:0]           start_locator,
    input  logic [1:0]                 start_state,
    input  logic [2*DW_PER_BLK-1:0]    start_header,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic [LOC_W+ALIGN_SH-1:0]  mem_req_addr,
    input  logic                       mem_rsp_valid,
    input  logic [WORD_W-1:0]          mem_rsp_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [2*WORD_W-1:0]        out_data,
    output logic                       out_last
);

    localparam int HDR_W  = 2 * DW_PER_BLK;
    localparam int IDX_W  = (DW_PER_BLK > 1) ? $clog2(DW_PER_BLK) : 1;
    localparam int STEP_B = WORD_W / 8;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DW_PER_BLK - 1);

    seq_state_e        seq_q;
    logic [1:0]        blk_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [IDX_W-1:0]  idx_q;
    dw_kind_e          kind_q;
    dw_kind_e          kind_next;
    logic              second_q;

    logic start_fire;
    logic req_fire;
    logic rsp_take;

    assign start_ready   = (seq_q == SQ_IDLE);
    assign start_fire    = start_valid && start_ready;
    assign mem_req_valid = (seq_q == SQ_REQ);
    assign req_fire      = mem_req_valid && mem_req_ready;
    assign rsp_take      = (seq_q == SQ_WAIT) && mem_rsp_valid;
    assign out_valid     = (seq_q == SQ_EMIT);
    assign out_last      = out_valid && (idx_q == LAST_IDX);

    hdr_code_map u_map (
        .blk_state (blk_q),
        .code      (hdr_q[HDR_W-1 -: 2]),
        .kind      (kind_next)
    );

    rd_ptr_gen #(
        .LOC_W    (LOC_W),
        .ALIGN_SH (ALIGN_SH),
        .STEP     (STEP_B)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_fire),
        .base_loc (start_locator),
        .advance  (req_fire),
        .addr     (mem_req_addr)
    );

    dw_builder #(
        .WORD_W (WORD_W)
    ) u_build (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (rsp_take),
        .cap_second (second_q),
        .cap_word   (mem_rsp_data),
        .kind       (kind_q),
        .dword      (out_data)
    );

    // Block sequencer: decode, fetch, emit for each double-word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= SQ_IDLE;
            blk_q    <= BLK_ZERO;
            hdr_q    <= '0;
            idx_q    <= '0;
            kind_q   <= DW_ZERO;
            second_q <= 1'b0;
        end else begin
            case (seq_q)
                SQ_IDLE: begin
                    if (start_valid) begin
                        blk_q <= start_state;
                        hdr_q <= start_header;
                        idx_q <= '0;
                        seq_q <= SQ_DECODE;
                    end
                end
                SQ_DECODE: begin
                    kind_q   <= kind_next;
                    second_q <= 1'b0;
                    seq_q    <= (kind_next == DW_ZERO) ? SQ_EMIT : SQ_REQ;
                end
                SQ_REQ: begin
                    if (mem_req_ready) seq_q <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (kind_q == DW_FULL && !second_q) begin
                            second_q <= 1'b1;
                            seq_q    <= SQ_REQ;
                        end else begin
                            seq_q <= SQ_EMIT;
                        end
                    end
                end
                SQ_EMIT: begin
                    if (out_ready) begin
                        if (idx_q == LAST_IDX) begin
                            seq_q <= SQ_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            hdr_q <= hdr_q << 2;
                            seq_q <= SQ_DECODE;
                        end
                    end
                end
                default: seq_q <= SQ_IDLE;
            endcase
        end
    end

    p_busy_blocks_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !start_ready);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_rsp_when_waiting_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (seq_q == SQ_WAIT));

    p_zero_block_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q == BLK_ZERO && seq_q != SQ_IDLE) |-> !mem_req_valid);

    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

endmodule

// File: tb/hdr_block_unpacker_test.sv
module hdr_block_unpacker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [31:0] start_locator = '0;
    logic [1:0]  start_state = '0;
    logic [31:0] start_header = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [34:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;
    logic        out_last;

    always #4 clk = ~clk;   // 125 MHz

    hdr_block_unpacker uut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_locator(start_locator), .start_state(start_state),
        .start_header(start_header),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    int tests = 0;
    int fails = 0;

    logic [63:0] exp_dw [16];
    string       exp_tag [16];
    logic [34:0] exp_addr [32];
    int          exp_nreq;
    int          out_k = 0;
    int          req_k = 0;
    int          lat_cfg = 1;
    int          bp_mode = 0;
    int          pend = 0;
    logic [34:0] pend_addr = '0;
    int          cyc = 0;
    bit          active = 1'b0;

    function automatic logic [31:0] mem_word(input logic [34:0] a);
        return (a[31:0] * 32'h9E3779B1) ^ {29'd0, a[34:32]} ^ 32'hA5C30F1E;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected stream from the requirements, walking the header top-down
    task automatic build_expect(input logic [31:0] loc, input logic [1:0] st,
                                input logic [31:0] hdr);
        logic [34:0] p = {loc, 3'b000};
        logic [31:0] w0, w1;
        exp_nreq = 0;
        for (int i = 0; i < 16; i++) begin
            logic [1:0] c = hdr[31-2*i -: 2];
            w0 = '0; w1 = '0;
            if (st == 2'b11) begin
                exp_dw[i] = '0; exp_tag[i] = "R9";
            end else if (st == 2'b10) begin
                exp_addr[exp_nreq++] = p; w0 = mem_word(p); p = p + 35'd4;
                exp_addr[exp_nreq++] = p; w1 = mem_word(p); p = p + 35'd4;
                exp_dw[i] = {w0, w1}; exp_tag[i] = "R8";
            end else begin
                if (c != 2'b00) begin
                    exp_addr[exp_nreq++] = p; w0 = mem_word(p); p = p + 35'd4;
                end
                if (c == 2'b11) begin
                    exp_addr[exp_nreq++] = p; w1 = mem_word(p); p = p + 35'd4;
                end
                case (c)
                    2'b00: begin exp_dw[i] = '0; exp_tag[i] = "R3/R4"; end
                    2'b01: begin exp_dw[i] = {32'h0, w0};
                                 exp_tag[i] = (st == 2'b00) ? "R3/R6" : "R3/R7"; end
                    2'b10: begin
                        if (st == 2'b00) begin exp_dw[i] = {w0, w0}; exp_tag[i] = "R3/R6"; end
                        else             begin exp_dw[i] = {w0, 32'h0}; exp_tag[i] = "R3/R7"; end
                    end
                    default: begin exp_dw[i] = {w0, w1}; exp_tag[i] = "R3/R5"; end
                endcase
            end
        end
    endtask

    // Memory and output models; ready is updated before handshakes are judged
    always @(negedge clk) begin
        cyc++;
        mem_req_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        out_ready     = (bp_mode == 0) ? 1'b1 :
                        (bp_mode == 1) ? ((cyc % 4) != 1) : ((cyc % 2) == 0);
        if (mem_rsp_valid) mem_rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(pend_addr);
            end
        end
        if (active && mem_req_valid && mem_req_ready) begin
            if (req_k < exp_nreq)
                check(mem_req_addr == exp_addr[req_k], "R2 read address",
                      64'(mem_req_addr), 64'(exp_addr[req_k]));
            else
                check(1'b0, "R11 unexpected read", 64'(mem_req_addr), 64'h0);
            req_k++;
            pend      = lat_cfg;
            pend_addr = mem_req_addr;
        end
        if (active && out_valid && out_ready) begin
            if (out_k < 16) begin
                check(out_data == exp_dw[out_k], exp_tag[out_k], out_data, exp_dw[out_k]);
                check(out_last == (out_k == 15), "R10 last flag",
                      64'(out_last), 64'(out_k == 15));
            end
            out_k++;
        end
    end

    task automatic run_block(input logic [31:0] loc, input logic [1:0] st,
                             input logic [31:0] hdr, input int lat, input int bp);
        build_expect(loc, st, hdr);
        lat_cfg = lat; bp_mode = bp;
        out_k = 0; req_k = 0; active = 1'b1;
        @(negedge clk);
        start_valid = 1'b1; start_locator = loc; start_state = st; start_header = hdr;
        while (!start_ready) @(negedge clk);
        @(negedge clk);
        start_valid = 1'b0;
        check(!start_ready, "R1 busy after accept", 64'(start_ready), 64'h0);
        while (out_k < 16) @(negedge clk);
        repeat (4) @(negedge clk);
        check(out_k == 16, "R10 output count", 64'(out_k), 64'd16);
        check(req_k == exp_nreq, (st == 2'b11) ? "R9 read count" : "R11 read count",
              64'(req_k), 64'(exp_nreq));
        check(start_ready, "R1 idle after block", 64'(start_ready), 64'h1);
        active = 1'b0;
    endtask

    // Watchdog: a hung run is one failed check
    always @(posedge clk) begin
        if (cyc > 190000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed = 32'h1234_5678;
        int n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(start_ready,    "R1 reset start_ready", 64'(start_ready), 64'h1);
        check(!out_valid,     "R1 reset out_valid", 64'(out_valid), 64'h0);
        check(!mem_req_valid, "R1 reset mem_req_valid", 64'(mem_req_valid), 64'h0);

        // Every code in every position under every block state
        for (int st = 0; st < 4; st++) begin
            for (int c = 0; c < 4; c++) begin
                run_block(32'h0000_1000 + 32'(n * 37), 2'(st), {16{2'(c)}},
                          1 + (n % 3), n % 3);
                n++;
            end
            run_block(32'h1FFF_FF00, 2'(st), 32'h1B1B_E4E4, 2, 1);   // R3 mixed order
            run_block(32'h0000_0000, 2'(st), 32'hC000_0003, 1, 0);   // R3 ends only
        end

        // Pseudo-random headers; uncompressed also checks that R8 ignores the header
        for (int k = 0; k < 120; k++) begin
            seed = next_rand(seed);
            begin
                logic [31:0] hdr = seed;
                seed = next_rand(seed);
                run_block(seed >> 1, 2'(k % 4), hdr, 1 + (k % 4), k % 3);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule